// File: doc/BRIEF.md
# Latched 16-bit Down-Counter Timer

This block is a reloadable interval timer built from a 16-bit latch and a 16-bit down-counter. The counter moves only on cycles where a tick-enable input is high, so one clock domain can run it at any rate a prescaler chooses. Software reaches the timer through four byte-wide register slots: two slots address the counter bytes and two address the latch bytes. Writing the counter's high byte copies the complete latch into the counter and starts a new count.

When a tick finds the counter at zero, the counter rolls over to all-ones and the block pulses its interrupt-set output for one cycle. A sticky flag holds that event until software clears it. A two-bit mode input selects between two behaviours. In continuous mode the counter reloads from the latch on the tick after the rollover, so interrupts repeat every latch+2 ticks. Any other mode value gives one-shot behaviour: one interrupt after each load, and the counter then keeps counting down without reloading.

Top module: `ldt_timer`

## Requirements
- R1: After reset the latch and the counter both hold 0xFFFF, the flag is clear and one-shot mode has no pending interrupt.
- R2: The counter changes only on a cycle with `tick_en` high or a counter-high write. A plain tick lowers it by one.
- R3: A write to slot 0 (counter low) or slot 2 (latch low) changes only the latch low byte. The counter keeps its value.
- R4: A write to slot 1 (counter high) stores the latch high byte, loads the counter with {written byte, latch low byte}, clears the flag and arms one-shot mode. This write wins over a tick in the same cycle, and no interrupt is raised in that cycle.
- R5: A write to slot 3 (latch high) stores the latch high byte and clears the flag. The counter is left unchanged.
- R6: `rdata` shows, with no added latency, the counter low byte for slot 0, the counter high byte for slot 1, the latch low byte for slot 2 and the latch high byte for slot 3.
- R7: A read strobe on slot 0 clears the flag. A read strobe on slot 1 leaves the flag as it is.
- R8: A tick that finds the counter at 0 sets it to 0xFFFF. If an interrupt is allowed, `irq_set` is high in that same cycle and the flag is set at the clock edge. Setting the flag wins over any clear in the same cycle.
- R9: In continuous mode (`mode` == 2'b01), the tick that follows a rollover reloads the counter from the latch. Interrupts then repeat every latch+2 ticks, and a latch of 0 gives a period of 2.
- R10: In every other mode value, only the first rollover after a counter-high write raises an interrupt. The counter then keeps decrementing through 0xFFFF without reloading, and later passes through zero stay silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| mode | input | 2 | Timer mode; 2'b01 selects continuous reload |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, used for read side effects |
| addr | input | 2 | Register slot: 0 counter low, 1 counter high, 2 latch low, 3 latch high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected slot |
| irq_set | output | 1 | Single-cycle pulse on an interrupting rollover |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Assertions run on every cycle and cover the following: the counter holds when nothing acts on it; a load lands the expected value; a rollover always leaves all-ones; a continuous-mode reload copies the latch; latch writes change only their own byte; the flag obeys its set and clear priority. The bench scenarios cover what needs a whole sequence of cycles: the exact latch+2 period, the interrupt count over many periods, and the silence in one-shot mode over a full 65536-tick wrap. They also cover how the flag moves through reads and writes, and the precedence of a load that arrives in the same cycle as a tick.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  typedef enum logic [1:0] {
    SLOT_CNT_LO = 2'd0,
    SLOT_CNT_HI = 2'd1,
    SLOT_LAT_LO = 2'd2,
    SLOT_LAT_HI = 2'd3
  } ldt_slot_e;

  localparam logic [1:0] MODE_CONTINUOUS = 2'b01;

  function automatic logic ldt_is_continuous(input logic [1:0] m);
    return m == MODE_CONTINUOUS;
  endfunction
endpackage

// File: rtl/ldt_latch.sv
module ldt_latch #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  latch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '1;
    end else begin
      if (wr_lo) latch[BYTE_W-1:0] <= wdata;
      if (wr_hi) latch[CNT_W-1:BYTE_W] <= wdata;
    end
  end

  // R5 / R4: high-byte write lands, low byte untouched
  assert_latch_hi_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi && !wr_lo |=> latch[CNT_W-1:BYTE_W] == $past(wdata)
                        && latch[BYTE_W-1:0] == $past(latch[BYTE_W-1:0]));
  // R3: low-byte write leaves the high byte alone
  assert_latch_lo_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && !wr_hi |=> latch[BYTE_W-1:0] == $past(wdata)
                        && latch[CNT_W-1:BYTE_W] == $past(latch[CNT_W-1:BYTE_W]));
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo && !wr_hi |=> $stable(latch));
endmodule

// File: rtl/ldt_counter.sv
module ldt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cont,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch,
  output logic [CNT_W-1:0] count,
  output logic             fire,
  output logic             reload_evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic wrapped;
  logic armed;
  logic at_zero;
  logic step;

  // next counter value on a tick: reload after a rollover in continuous mode
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lat,
    input logic             was_wrapped,
    input logic             is_cont);
    if (was_wrapped && is_cont) return lat;
    return cur - 1'b1;
  endfunction

  assign step       = tick && !load;
  assign at_zero    = (count == '0);
  assign fire       = step && at_zero && (cont || armed);
  assign reload_evt = step && wrapped && cont;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= ALL_ONES;
      wrapped <= 1'b0;
      armed   <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      wrapped <= 1'b0;
      armed   <= 1'b1;
    end else if (tick) begin
      count   <= next_count(count, latch, wrapped, cont);
      wrapped <= at_zero;
      if (fire) armed <= 1'b0;
    end
  end

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(count));
  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  assert_rollover_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> count == ALL_ONES);
  assert_reload_from_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> count == $past(latch));
  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cont |=> !fire);
endmodule

// File: rtl/ldt_flag.sv
module ldt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !set |=> flag == $past(flag));
endmodule

// File: rtl/ldt_timer.sv
module ldt_timer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_set,
  output logic              irq_flag
);
  import ldt_pkg::*;
  localparam int CNT_W = 2 * BYTE_W;

  ldt_slot_e        slot;
  logic             wr_lat_lo;
  logic             wr_lat_hi;
  logic             load_cnt;
  logic             flag_clr;
  logic             cont;
  logic [CNT_W-1:0] latch;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;
  logic             fire;
  logic             reload_evt;

  assign slot      = ldt_slot_e'(addr);
  assign cont      = ldt_is_continuous(mode);
  assign wr_lat_lo = wr_en && (slot == SLOT_CNT_LO || slot == SLOT_LAT_LO);
  assign wr_lat_hi = wr_en && (slot == SLOT_CNT_HI || slot == SLOT_LAT_HI);
  assign load_cnt  = wr_en && (slot == SLOT_CNT_HI);
  assign load_val  = {wdata, latch[BYTE_W-1:0]};
  assign flag_clr  = wr_lat_hi || (rd_en && slot == SLOT_CNT_LO);

  ldt_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lat_lo),
    .wr_hi (wr_lat_hi),
    .wdata (wdata),
    .latch (latch)
  );

  ldt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .cont       (cont),
    .load       (load_cnt),
    .load_val   (load_val),
    .latch      (latch),
    .count      (count),
    .fire       (fire),
    .reload_evt (reload_evt)
  );

  ldt_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fire),
    .clr   (flag_clr),
    .flag  (irq_flag)
  );

  always_comb begin
    unique case (slot)
      SLOT_CNT_LO: rdata = count[BYTE_W-1:0];
      SLOT_CNT_HI: rdata = count[CNT_W-1:BYTE_W];
      SLOT_LAT_LO: rdata = latch[BYTE_W-1:0];
      default:     rdata = latch[CNT_W-1:BYTE_W];
    endcase
  end

  assign irq_set = fire;

  // R4: a counter-high write never raises an interrupt in its own cycle
  assert_load_blocks_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_cnt |-> !irq_set);
  // R7: a high-byte counter read alone keeps the flag
  assert_hi_read_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && slot == SLOT_CNT_HI && !wr_en && irq_flag |=> irq_flag);
  // R6: counter low byte is what rdata shows in slot 0
  assert_read_cnt_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot == SLOT_CNT_LO |-> rdata == count[BYTE_W-1:0]);
endmodule

// File: tb/tb_ldt_timer.sv
module tb_ldt_timer;
  localparam logic [1:0] OP_MODE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_TICK = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  idx;
    logic [15:0] arg;   // write data, mode, or tick count
    logic [7:0]  exp;   // read data or expected interrupt count
    logic        flag;  // expected flag after the step
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{OP_MODE, 2'd0, 16'd1,  8'h00, 1'b0, 4'd9},
    '{OP_WR,   2'd2, 16'h03, 8'h00, 1'b0, 4'd3},
    '{OP_WR,   2'd1, 16'h00, 8'h00, 1'b0, 4'd4},
    '{OP_RD,   2'd0, 16'd0,  8'h03, 1'b0, 4'd6},
    '{OP_TICK, 2'd0, 16'd3,  8'd0,  1'b0, 4'd2},
    '{OP_RD,   2'd0, 16'd0,  8'h00, 1'b0, 4'd6},
    '{OP_TICK, 2'd0, 16'd1,  8'd1,  1'b1, 4'd8},
    '{OP_RD,   2'd1, 16'd0,  8'hFF, 1'b1, 4'd7},
    '{OP_RD,   2'd0, 16'd0,  8'hFF, 1'b0, 4'd7},
    '{OP_TICK, 2'd0, 16'd1,  8'd0,  1'b0, 4'd9},
    '{OP_RD,   2'd0, 16'd0,  8'h03, 1'b0, 4'd9},
    '{OP_TICK, 2'd0, 16'd10, 8'd2,  1'b1, 4'd9},
    '{OP_WR,   2'd3, 16'h01, 8'h00, 1'b0, 4'd5},
    '{OP_RD,   2'd1, 16'd0,  8'h00, 1'b0, 4'd5},
    '{OP_RD,   2'd3, 16'd0,  8'h01, 1'b0, 4'd6},
    '{OP_RD,   2'd2, 16'd0,  8'h03, 1'b0, 4'd6},
    '{OP_WR,   2'd0, 16'h07, 8'h00, 1'b0, 4'd3},
    '{OP_RD,   2'd0, 16'd0,  8'h03, 1'b0, 4'd3},
    '{OP_RD,   2'd2, 16'd0,  8'h07, 1'b0, 4'd3},
    '{OP_TICK, 2'd0, 16'd5,  8'd1,  1'b1, 4'd9},
    '{OP_RD,   2'd1, 16'd0,  8'h01, 1'b1, 4'd7},
    '{OP_RD,   2'd0, 16'd0,  8'h07, 1'b0, 4'd9},
    '{OP_MODE, 2'd0, 16'd0,  8'h00, 1'b0, 4'd10},
    '{OP_WR,   2'd2, 16'h02, 8'h00, 1'b0, 4'd4},
    '{OP_WR,   2'd1, 16'h00, 8'h00, 1'b0, 4'd4},
    '{OP_TICK, 2'd0, 16'd3,  8'd1,  1'b1, 4'd10},
    '{OP_TICK, 2'd0, 16'd1,  8'd0,  1'b1, 4'd10},
    '{OP_RD,   2'd0, 16'd0,  8'hFE, 1'b0, 4'd10},
    '{OP_RD,   2'd1, 16'd0,  8'hFF, 1'b0, 4'd10},
    '{OP_MODE, 2'd0, 16'd2,  8'h00, 1'b0, 4'd10},
    '{OP_TICK, 2'd0, 16'd2,  8'd0,  1'b0, 4'd10},
    '{OP_RD,   2'd0, 16'd0,  8'hFC, 1'b0, 4'd10},
    '{OP_MODE, 2'd0, 16'd1,  8'h00, 1'b0, 4'd9},
    '{OP_WR,   2'd2, 16'h00, 8'h00, 1'b0, 4'd4},
    '{OP_WR,   2'd1, 16'h00, 8'h00, 1'b0, 4'd4},
    '{OP_TICK, 2'd0, 16'd4,  8'd2,  1'b1, 4'd9},
    '{OP_RD,   2'd0, 16'd0,  8'h00, 1'b0, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_set;
  logic       irq_flag;

  int n_checks = 0;
  int n_fail = 0;
  int events;
  logic [7:0] got;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ldt_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_set(irq_set), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tick_en = with_tick;
    #1 events = irq_set ? 1 : 0;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_ticks(input int n, output int ev);
    ev = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      #1 if (irq_set) ev++;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2 actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    do_rd(2'd0, got); check(got == 8'hFF, "R1 cnt lo", got, 8'hFF);
    do_rd(2'd1, got); check(got == 8'hFF, "R1 cnt hi", got, 8'hFF);
    do_rd(2'd2, got); check(got == 8'hFF, "R1 lat lo", got, 8'hFF);
    do_rd(2'd3, got); check(got == 8'hFF, "R1 lat hi", got, 8'hFF);
    check(irq_flag == 1'b0, "R1 flag", irq_flag, 0);

    // R2: no tick, no change
    repeat (5) @(negedge clk);
    do_rd(2'd0, got); check(got == 8'hFF, "R2 idle hold", got, 8'hFF);
    // R1: one-shot not armed out of reset, first tick just decrements
    do_ticks(1, events); check(events == 0, "R1 no irq", events, 0);
    do_rd(2'd0, got); check(got == 8'hFE, "R2 decrement", got, 8'hFE);

    for (int v = 0; v < NV; v++) begin
      vec_t e = VECS[v];
      string tag = $sformatf("R%0d step %0d", e.req, v);
      case (e.op)
        OP_MODE: mode = e.arg[1:0];
        OP_WR: begin
          do_wr(e.idx, e.arg[7:0], 1'b0);
          check(irq_flag == e.flag, {tag, " flag"}, irq_flag, e.flag);
        end
        OP_RD: begin
          do_rd(e.idx, got);
          check(got == e.exp, {tag, " rdata"}, got, e.exp);
          check(irq_flag == e.flag, {tag, " flag"}, irq_flag, e.flag);
        end
        default: begin
          do_ticks(int'(e.arg), events);
          check(events == int'(e.exp), {tag, " irq count"}, events, e.exp);
          check(irq_flag == e.flag, {tag, " flag"}, irq_flag, e.flag);
        end
      endcase
    end

    // R4: load wins over a simultaneous tick, no irq in that cycle
    mode = 2'b01;
    do_wr(2'd2, 8'h10, 1'b0);
    do_wr(2'd1, 8'h00, 1'b1);
    check(events == 0, "R4 load+tick irq", events, 0);
    do_rd(2'd0, got); check(got == 8'h10, "R4 load beats tick", got, 8'h10);

    // R8: rollover and counter-low read in the same cycle, set wins
    do_wr(2'd2, 8'h01, 1'b0);
    do_wr(2'd1, 8'h00, 1'b0);
    do_ticks(1, events);
    @(negedge clk);
    rd_en = 1'b1; addr = 2'd0; tick_en = 1'b1;
    #1 check(irq_set == 1'b1, "R8 pulse", irq_set, 1);
    @(negedge clk);
    rd_en = 1'b0; tick_en = 1'b0;
    check(irq_flag == 1'b1, "R8 set beats clear", irq_flag, 1);

    // R10: one-shot stays silent over a full wrap after its single event
    mode = 2'b11;
    do_wr(2'd2, 8'h05, 1'b0);
    do_wr(2'd1, 8'h00, 1'b0);
    check(irq_flag == 1'b0, "R10 flag cleared by load", irq_flag, 0);
    do_ticks(6, events); check(events == 1, "R10 first pass", events, 1);
    do_ticks(65536, events); check(events == 0, "R10 later passes", events, 0);
    do_rd(2'd0, got); check(got == 8'hFF, "R10 cnt lo after wrap", got, 8'hFF);
    do_rd(2'd1, got); check(got == 8'hFF, "R10 cnt hi after wrap", got, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule